// File: doc/BRIEF.md
# Ordered Key Unlock Gate

This block grants access to a protected information region of a memory. It watches a single 32-bit control register that software can only write. Access is granted only after three fixed key words have been written to that register in a set order. The memory controller next to the gate takes the permission level from `access_ok` and uses it to allow or block reads and writes to the system and user information areas. The gate itself enforces nothing on the memory.

The register decode is done outside the block, so `wr_en` and `rd_en` already qualify an access to this register. A wrong word anywhere in the sequence sends the tracker back to its start. The one exception is a wrong word equal to the first key, which counts as step one. Once the gate is open, any write to the register closes it again. Reads of the register always return zero, so the keys cannot be read back.

Top module: `key_unlock_gate`

## Requirements
- R1: During and after reset the gate is locked (`access_ok` = 0) and the sequence tracker is at its first step.
- R2: Writing 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 opens the gate. `access_ok` goes to 1 on the rising edge that samples the third write.
- R3: A locked-state write that does not match the expected key sends the tracker back to step zero. If that write equals 0x3A7F5CA3, it counts as the first key instead.
- R4: While the gate is open, any write (of any value, including a key word) locks it on the edge that samples the write. The tracker restarts at step zero.
- R5: `rd_data` is zero at all times, whether or not `rd_en` is asserted and whatever the gate state.
- R6: Cycles without `wr_en` leave the gate state and the tracker step unchanged, so idle gaps between key words are allowed.
- R7: A partial sequence (one or two correct keys) never raises `access_ok`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the access-control register |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for the access-control register |
| access_ok | output | 1 | Read/write permission for the protected region |
| rd_data | output | 32 | Register read data, always zero |

## Verification
Every result of a write appears exactly one rising edge later. `access_ok` changes on the same edge that samples the completing or relocking write. `rd_data` holds zero with no latency. The bench drives inputs on falling edges. A behavioural model updates on each rising edge from the same sampled inputs, and the outputs are compared with it on the next falling edge. Each comparison therefore sees the state that the just-sampled write produced. Directed checks at fixed points add explicit expected values for the ordering, restart, relock and idle-gap cases.

// File: rtl/unlock_gate_pkg.sv
package unlock_gate_pkg;
    localparam int WORD_W   = 32;
    localparam int KEY_CNT  = 3;

    typedef logic [WORD_W-1:0] word_t;

    // Keys in required write order: index 0 first.
    localparam logic [KEY_CNT-1:0][WORD_W-1:0] DEFAULT_KEYS = {
        32'h9608_B2C1,
        32'hA1E3_4F20,
        32'h3A7F_5CA3
    };
endpackage

// File: rtl/key_matcher.sv
module key_matcher #(
    parameter int NUM_KEYS = 3,
    parameter int WORD_W   = 32,
    parameter logic [NUM_KEYS-1:0][WORD_W-1:0] KEYS = '0
) (
    input  logic [WORD_W-1:0]   word_i,
    output logic [NUM_KEYS-1:0] hit_o
);
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
        assign hit_o[k] = (word_i == KEYS[k]);
    end
endmodule

// File: rtl/seq_tracker.sv
module seq_tracker #(
    parameter int NUM_KEYS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_KEYS-1:0] hit_i,
    output logic                open_o
);
    localparam int STEP_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_KEYS - 1);

    typedef struct packed {
        logic              open;
        logic [STEP_W-1:0] step;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (wr_en) begin
            if (trk_q.open) begin
                trk_d.open = 1'b0;
                trk_d.step = '0;
            end else if (hit_i[trk_q.step]) begin
                if (trk_q.step == LAST_STEP) begin
                    trk_d.open = 1'b1;
                    trk_d.step = '0;
                end else begin
                    trk_d.step = trk_q.step + 1'b1;
                end
            end else if (hit_i[0]) begin
                trk_d.step = STEP_W'(1);
            end else begin
                trk_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign open_o = trk_q.open;

    // R4: an open gate closes after any write
    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.open && wr_en) |=> !trk_q.open);
    // R2: opening only follows a write that matched the final key
    p_open_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trk_q.open) |-> ($past(wr_en) && $past(hit_i[NUM_KEYS-1])));
    // R6: no write, no change
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(trk_q.open) && $stable(trk_q.step)));
    // R1: step stays in range, and is zero while open
    p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.step <= LAST_STEP) && (!trk_q.open || trk_q.step == '0));
    // R3: a locked mismatching write that is not the first key restarts
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trk_q.open && hit_i == '0) |=> (trk_q.step == '0 && !trk_q.open));
endmodule

// File: rtl/key_unlock_gate.sv
module key_unlock_gate
    import unlock_gate_pkg::*;
#(
    parameter int NUM_KEYS = KEY_CNT,
    parameter logic [NUM_KEYS-1:0][WORD_W-1:0] KEYS = DEFAULT_KEYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              access_ok,
    output logic [WORD_W-1:0] rd_data
);
    logic [NUM_KEYS-1:0] hit;
    word_t rd_d, rd_q;

    key_matcher #(
        .NUM_KEYS (NUM_KEYS),
        .WORD_W   (WORD_W),
        .KEYS     (KEYS)
    ) u_match (
        .word_i (wr_data),
        .hit_o  (hit)
    );

    seq_tracker #(
        .NUM_KEYS (NUM_KEYS)
    ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .hit_i  (hit),
        .open_o (access_ok)
    );

    // Readback path: the register is write-only, reads yield zero.
    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R5: a read strobe never exposes written data
    p_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == '0));
endmodule

// File: tb/key_unlock_gate_bench.sv
module key_unlock_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        access_ok;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    localparam logic [31:0] K0 = 32'h3A7F5CA3;
    localparam logic [31:0] K1 = 32'hA1E34F20;
    localparam logic [31:0] K2 = 32'h9608B2C1;

    always #5 clk = ~clk;

    key_unlock_gate u_key_unlock_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .access_ok(access_ok), .rd_data(rd_data)
    );

    // Behavioural reference: queue of expected key words still to come.
    logic [31:0] keys[$];
    int  pos = 0;
    bit  m_open = 0;

    initial keys = '{K0, K1, K2};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos = 0; m_open = 0;
        end else if (wr_en) begin
            if (m_open) begin
                m_open = 0; pos = 0;
            end else if (wr_data == keys[pos]) begin
                pos = pos + 1;
                if (pos == keys.size()) begin m_open = 1; pos = 0; end
            end else begin
                pos = (wr_data == keys[0]) ? 1 : 0;
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        check({tag, " model access_ok"}, {31'd0, access_ok}, {31'd0, m_open});
        check("R5 rd_data zero", rd_data, 32'd0);
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        #1 wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ok(input string t, input logic e);
        #2 check(t, {31'd0, access_ok}, {31'd0, e});
    endtask

    initial begin : watchdog
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tag = "R1";
        idle(3);
        expect_ok("R1 locked in reset", 1'b0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        expect_ok("R1 locked after reset", 1'b0);

        tag = "R2";
        wr(K0); wr(K1);
        expect_ok("R7 two keys not enough", 1'b0);
        wr(K2);
        expect_ok("R2 full sequence opens", 1'b1);

        tag = "R5";
        @(negedge clk) rd_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        idle(3);
        #1 rd_en = 1'b0;
        expect_ok("R5 read leaves gate open", 1'b1);

        tag = "R4";
        wr(K0);
        expect_ok("R4 key word relocks", 1'b0);
        wr(K0); wr(K1); wr(K2);
        expect_ok("R2 reopen", 1'b1);
        wr(32'h0);
        expect_ok("R4 zero write relocks", 1'b0);

        tag = "R3";
        wr(K0); wr(32'h1234_5678); wr(K1); wr(K2);
        expect_ok("R3 wrong word restarts", 1'b0);
        wr(K0); wr(K0); wr(K1); wr(K2);
        expect_ok("R3 first key resyncs", 1'b1);
        wr(32'h5);
        wr(K0); wr(K1); wr(K0); wr(K1); wr(K2);
        expect_ok("R3 first key mid-sequence", 1'b1);
        wr(32'h5);
        wr(K1); wr(K2);
        expect_ok("R7 out of order", 1'b0);
        wr(K2); wr(K1); wr(K0);
        expect_ok("R7 reversed order", 1'b0);

        tag = "R6";
        wr(32'h0);
        wr(K0); idle(5); wr(K1); idle(7); wr(K2);
        expect_ok("R6 gaps allowed", 1'b1);
        idle(10);
        expect_ok("R6 open holds without writes", 1'b1);
        wr(K2);
        expect_ok("R4 last key relocks", 1'b0);

        tag = "R1";
        wr(K0); wr(K1);
        @(negedge clk) rst_n = 1'b0;
        idle(2);
        @(negedge clk) rst_n = 1'b1;
        wr(K2);
        expect_ok("R1 reset clears progress", 1'b0);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule